// File: doc/BRIEF.md
# Synapse Dispatch Controller

This block sits between incoming spike events and the weight logic of a board that hosts part of a spiking neural network. Each spike that arrives carries the address of the neuron that fired. The spike goes into a small queue. When the controller is idle it takes the oldest spike and walks every possible target neuron of that sender in ascending index order. For each target it reads a connection record that holds a plastic bit, a weight and a sign bit. It also reads a per-neuron flag that says whether the target lives on this board.

For an absent connection the controller moves on. A connection whose target is remote produces one transfer on a bus output, carrying the sender and the target. A local connection that is not plastic sends its stored weight to the neuron unchanged. A local plastic connection raises a request to an external plasticity engine and holds it until the engine answers. The engine's result is written back into the weight store, and the new weight is then delivered. The next spike is taken only once the whole walk has finished.

Neuron flags and connection records are loaded through two simple write ports, and these ports stay usable while a walk is in progress. All arithmetic is done by the engine outside this block.

Top module: `synapse_dispatch`

## Requirements
- R1: Spikes are processed one at a time in arrival order. The oldest queued spike is taken only when no walk is active, and the taken address is the sender on every bus, engine and delivery output of that walk.
- R2: The queue holds FIFO_DEPTH spikes, and `fifo_full` is high exactly when it holds that many. A spike offered while the queue is full is discarded, even when a spike is taken in the same cycle. Each discarded spike raises `drop_count` by one, and `drop_count` stops at its all-ones value.
- R3: A walk visits targets 0 to NUM_NEURONS-1 in ascending order, spending one cycle per target plus any wait. A connection with plastic bit 0 and weight 0 is absent and produces no output.
- R4: An existing connection to a target whose local flag is 0 raises `bus_valid` with `bus_src` = sender and `bus_dst` = target. These are held stable until `bus_ready` is high at a clock edge. Such a connection raises neither the engine request nor a delivery.
- R5: An existing connection with plastic bit 1 to a local target raises `eng_valid` with the pair, its current weight and its sign. The pair is held until `eng_done` is high at a clock edge, and at that edge `eng_result` is stored as the connection's weight.
- R6: In the cycle after `eng_done` is accepted, `dlv_valid` is high for one cycle, with the target and the weight just stored.
- R7: An existing non-plastic connection to a local target gives a one-cycle `dlv_valid` in its own scan cycle, with the stored weight unchanged and its sign bit. Sign 1 means excitatory and sign 0 means inhibitory.
- R8: `syn_we` writes the plastic bit, weight and sign of cell (`syn_pre`, `syn_post`). `nrn_we` writes the local flag of `nrn_addr`. Both take effect from the next cycle. If an engine writeback and `syn_we` hit the same cell in one cycle, the engine's weight is kept.
- R9: After reset the queue is empty, `drop_count` is 0, all valid outputs are low, and every connection is absent with every neuron marked remote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spike_valid | input | 1 | A spike is offered this cycle |
| spike_addr | input | ADDR_W | Address of the firing neuron |
| fifo_full | output | 1 | Spike queue is full |
| drop_count | output | DROP_W | Saturating count of discarded spikes |
| nrn_we | input | 1 | Write the local flag of a neuron |
| nrn_addr | input | ADDR_W | Neuron written by nrn_we |
| nrn_local | input | 1 | 1 = neuron is on this board |
| syn_we | input | 1 | Write one connection record |
| syn_pre | input | ADDR_W | Sending neuron of the record |
| syn_post | input | ADDR_W | Receiving neuron of the record |
| syn_plastic | input | 1 | Plastic bit |
| syn_weight | input | WEIGHT_W | Weight value |
| syn_excit | input | 1 | Sign bit, 1 = excitatory |
| eng_valid | output | 1 | Plasticity computation request |
| eng_pre | output | ADDR_W | Sender of the connection to update |
| eng_post | output | ADDR_W | Target of the connection to update |
| eng_weight | output | WEIGHT_W | Current weight of that connection |
| eng_excit | output | 1 | Sign bit of that connection |
| eng_done | input | 1 | Engine has finished, result valid |
| eng_result | input | WEIGHT_W | Updated weight from the engine |
| bus_valid | output | 1 | Forward request to a remote board |
| bus_ready | input | 1 | Bus accepts the forward request |
| bus_src | output | ADDR_W | Sender address being forwarded |
| bus_dst | output | ADDR_W | Remote target of the forward |
| dlv_valid | output | 1 | Weight delivery to a local neuron |
| dlv_target | output | ADDR_W | Local neuron receiving the weight |
| dlv_weight | output | WEIGHT_W | Weight delivered |
| dlv_excit | output | 1 | Sign of the delivered weight |

## Verification
Two pairs of events can land on the same clock edge, and the bench provokes both. First, the queue can be taken by the walker in the same cycle that a new spike is offered to a full queue. A long burst of spikes with the valid held high, while walks run, makes this happen many times. Second, a configuration write can land on the cell the engine is writing back. Configuration writes are scattered at random through the busy phase, so some coincide with engine completions. A behavioural model in the bench, built from queues and arrays, states which spike is dropped and which weight survives. Every output is compared with that model on every cycle.

// File: rtl/sd_pkg.sv
package sd_pkg;

    // Phases of one spike's walk over its target list.
    typedef enum logic [2:0] {
        WK_IDLE = 3'd0,   // waiting for a queued spike
        WK_SCAN = 3'd1,   // classifying the current target
        WK_FWD  = 3'd2,   // holding a remote forward until accepted
        WK_ENG  = 3'd3,   // holding a plasticity request until done
        WK_DLV  = 3'd4    // delivering a freshly stored weight
    } walk_state_e;

    // A connection exists unless both plastic bit and weight are zero.
    function automatic logic link_present(input logic plastic, input logic weight_nz);
        return plastic | weight_nz;
    endfunction

endpackage

// File: rtl/sd_spike_fifo.sv
module sd_spike_fifo #(
    parameter int DEPTH  = 16,
    parameter int AW     = 5,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [AW-1:0]     push_addr,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [AW-1:0]     head,
    output logic [DROP_W-1:0] drop_count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    typedef struct packed {
        logic [PW-1:0]     wr;
        logic [PW-1:0]     rd;
        logic [CW-1:0]     cnt;
        logic [DROP_W-1:0] drops;
    } fifo_t;

    fifo_t q, d;
    logic [AW-1:0] slot_q [DEPTH];
    logic accept, take;

    always_comb begin
        d      = q;
        full   = (q.cnt == CW'(DEPTH));
        empty  = (q.cnt == '0);
        accept = push_valid && !full;
        take   = pop && !empty;
        if (accept) begin
            d.wr = (q.wr == PW'(DEPTH - 1)) ? '0 : q.wr + PW'(1);
        end
        if (take) begin
            d.rd = (q.rd == PW'(DEPTH - 1)) ? '0 : q.rd + PW'(1);
        end
        d.cnt = q.cnt + CW'(accept) - CW'(take);
        if (push_valid && full && (q.drops != DROP_MAX)) begin
            d.drops = q.drops + DROP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            slot_q[q.wr] <= push_addr;
        end
    end

    assign head       = slot_q[q.rd];
    assign drop_count = q.drops;

    // R2: occupancy never exceeds the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R2: a spike offered to a full queue bumps the drop counter
    p_drop_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && drop_count != DROP_MAX)
        |=> drop_count == DROP_W'($past(drop_count) + 1'b1));

    // R2: the drop counter never moves backwards
    p_drop_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count >= $past(drop_count));

    // R1: the walker only takes from a non-empty queue
    p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sd_syn_table.sv
module sd_syn_table #(
    parameter int N  = 32,
    parameter int AW = 5,
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nrn_we,
    input  logic [AW-1:0] nrn_addr,
    input  logic          nrn_local,
    input  logic          syn_we,
    input  logic [AW-1:0] syn_pre,
    input  logic [AW-1:0] syn_post,
    input  logic          syn_plastic,
    input  logic [WW-1:0] syn_weight,
    input  logic          syn_excit,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_pre,
    input  logic [AW-1:0] wb_post,
    input  logic [WW-1:0] wb_weight,
    input  logic [AW-1:0] rd_pre,
    input  logic [AW-1:0] rd_post,
    output logic          rd_plastic,
    output logic [WW-1:0] rd_weight,
    output logic          rd_excit,
    output logic          rd_local
);
    // N is a power of two, so a cell index is {pre, post}.
    localparam int IW    = 2 * AW;
    localparam int CELLS = N * N;

    logic [CELLS-1:0] plastic_q, plastic_d;
    logic [CELLS-1:0] excit_q,   excit_d;
    logic [N-1:0]     local_q,   local_d;
    logic [WW-1:0]    weight_q [CELLS];
    logic [WW-1:0]    weight_d [CELLS];

    logic [IW-1:0] cfg_idx, wb_idx, rd_idx;
    assign cfg_idx = {syn_pre, syn_post};
    assign wb_idx  = {wb_pre, wb_post};
    assign rd_idx  = {rd_pre, rd_post};

    always_comb begin
        plastic_d = plastic_q;
        excit_d   = excit_q;
        local_d   = local_q;
        weight_d  = weight_q;
        if (nrn_we) begin
            local_d[nrn_addr] = nrn_local;
        end
        if (syn_we) begin
            plastic_d[cfg_idx] = syn_plastic;
            excit_d[cfg_idx]   = syn_excit;
            weight_d[cfg_idx]  = syn_weight;
        end
        // engine writeback is applied last so it wins on a shared cell
        if (wb_en) begin
            weight_d[wb_idx] = wb_weight;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plastic_q <= '0;
            excit_q   <= '0;
            local_q   <= '0;
            weight_q  <= '{default: '0};
        end else begin
            plastic_q <= plastic_d;
            excit_q   <= excit_d;
            local_q   <= local_d;
            weight_q  <= weight_d;
        end
    end

    assign rd_plastic = plastic_q[rd_idx];
    assign rd_excit   = excit_q[rd_idx];
    assign rd_weight  = weight_q[rd_idx];
    assign rd_local   = local_q[rd_post];

    // R8: a writeback is visible on the read port one cycle later
    p_wb_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_pre == rd_pre && wb_post == rd_post)
        |=> ($past(rd_pre) != rd_pre || $past(rd_post) != rd_post
             || rd_weight == $past(wb_weight)));

endmodule

// File: rtl/sd_walker.sv
module sd_walker
    import sd_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 5,
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_empty,
    input  logic [AW-1:0] fifo_head,
    output logic          fifo_pop,
    output logic [AW-1:0] rd_pre,
    output logic [AW-1:0] rd_post,
    input  logic          rd_plastic,
    input  logic [WW-1:0] rd_weight,
    input  logic          rd_excit,
    input  logic          rd_local,
    output logic          wb_en,
    output logic [AW-1:0] wb_pre,
    output logic [AW-1:0] wb_post,
    output logic [WW-1:0] wb_weight,
    output logic          eng_valid,
    output logic [AW-1:0] eng_pre,
    output logic [AW-1:0] eng_post,
    output logic [WW-1:0] eng_weight,
    output logic          eng_excit,
    input  logic          eng_done,
    input  logic [WW-1:0] eng_result,
    output logic          bus_valid,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_src,
    output logic [AW-1:0] bus_dst,
    output logic          dlv_valid,
    output logic [AW-1:0] dlv_target,
    output logic [WW-1:0] dlv_weight,
    output logic          dlv_excit
);
    localparam logic [AW-1:0] LAST_TGT = AW'(N - 1);

    typedef struct packed {
        walk_state_e   st;
        logic [AW-1:0] sender;
        logic [AW-1:0] tgt;
    } walk_t;

    walk_t q, d;
    logic present, step_on, static_hit;

    always_comb begin
        d          = q;
        fifo_pop   = 1'b0;
        wb_en      = 1'b0;
        step_on    = 1'b0;
        present    = link_present(rd_plastic, rd_weight != '0);
        static_hit = (q.st == WK_SCAN) && present && rd_local && !rd_plastic;

        unique case (q.st)
            WK_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.sender = fifo_head;
                    d.tgt    = '0;
                    d.st     = WK_SCAN;
                end
            end
            WK_SCAN: begin
                if (!present)        step_on = 1'b1;
                else if (!rd_local)  d.st    = WK_FWD;
                else if (rd_plastic) d.st    = WK_ENG;
                else                 step_on = 1'b1;
            end
            WK_FWD: begin
                if (bus_ready) step_on = 1'b1;
            end
            WK_ENG: begin
                if (eng_done) begin
                    wb_en = 1'b1;
                    d.st  = WK_DLV;
                end
            end
            WK_DLV: begin
                step_on = 1'b1;
            end
            default: d.st = WK_IDLE;
        endcase

        if (step_on) begin
            if (q.tgt == LAST_TGT) begin
                d.st = WK_IDLE;
            end else begin
                d.tgt = q.tgt + AW'(1);
                d.st  = WK_SCAN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: WK_IDLE, sender: '0, tgt: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_pre     = q.sender;
    assign rd_post    = q.tgt;
    assign wb_pre     = q.sender;
    assign wb_post    = q.tgt;
    assign wb_weight  = eng_result;

    assign bus_valid  = (q.st == WK_FWD);
    assign bus_src    = q.sender;
    assign bus_dst    = q.tgt;

    assign eng_valid  = (q.st == WK_ENG);
    assign eng_pre    = q.sender;
    assign eng_post   = q.tgt;
    assign eng_weight = rd_weight;
    assign eng_excit  = rd_excit;

    assign dlv_valid  = (q.st == WK_DLV) || static_hit;
    assign dlv_target = q.tgt;
    assign dlv_weight = rd_weight;
    assign dlv_excit  = rd_excit;

    // R4: a forward stays put until the bus takes it
    p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready)
        |=> (bus_valid && $stable(bus_src) && $stable(bus_dst)));

    // R5: an engine request stays put until the engine answers
    p_eng_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && !eng_done)
        |=> (eng_valid && $stable(eng_pre) && $stable(eng_post)));

    // R6: an accepted result is delivered in the next cycle
    p_dlv_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_done)
        |=> (dlv_valid && dlv_target == $past(eng_post) && dlv_weight == $past(eng_result)));

    // R4: bus, engine and delivery never overlap
    p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_valid, eng_valid, dlv_valid}));

    // R1: a new spike is only taken when no walk is active
    p_pop_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !(bus_valid || eng_valid || dlv_valid));

    // R3: targets are visited in ascending order during a walk
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != WK_IDLE && $past(q.st) != WK_IDLE) |-> q.tgt >= $past(q.tgt));

endmodule

// File: rtl/synapse_dispatch.sv
module synapse_dispatch #(
    parameter int NUM_NEURONS = 32,
    parameter int FIFO_DEPTH  = 16,
    parameter int WEIGHT_W    = 8,
    parameter int DROP_W      = 8,
    localparam int ADDR_W     = $clog2(NUM_NEURONS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spike_valid,
    input  logic [ADDR_W-1:0]   spike_addr,
    output logic                fifo_full,
    output logic [DROP_W-1:0]   drop_count,
    input  logic                nrn_we,
    input  logic [ADDR_W-1:0]   nrn_addr,
    input  logic                nrn_local,
    input  logic                syn_we,
    input  logic [ADDR_W-1:0]   syn_pre,
    input  logic [ADDR_W-1:0]   syn_post,
    input  logic                syn_plastic,
    input  logic [WEIGHT_W-1:0] syn_weight,
    input  logic                syn_excit,
    output logic                eng_valid,
    output logic [ADDR_W-1:0]   eng_pre,
    output logic [ADDR_W-1:0]   eng_post,
    output logic [WEIGHT_W-1:0] eng_weight,
    output logic                eng_excit,
    input  logic                eng_done,
    input  logic [WEIGHT_W-1:0] eng_result,
    output logic                bus_valid,
    input  logic                bus_ready,
    output logic [ADDR_W-1:0]   bus_src,
    output logic [ADDR_W-1:0]   bus_dst,
    output logic                dlv_valid,
    output logic [ADDR_W-1:0]   dlv_target,
    output logic [WEIGHT_W-1:0] dlv_weight,
    output logic                dlv_excit
);
    logic                fifo_empty, fifo_pop;
    logic [ADDR_W-1:0]   fifo_head;
    logic [ADDR_W-1:0]   rd_pre, rd_post, wb_pre, wb_post;
    logic                rd_plastic, rd_excit, rd_local, wb_en;
    logic [WEIGHT_W-1:0] rd_weight, wb_weight;

    sd_spike_fifo #(
        .DEPTH  (FIFO_DEPTH),
        .AW     (ADDR_W),
        .DROP_W (DROP_W)
    ) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (spike_valid),
        .push_addr  (spike_addr),
        .pop        (fifo_pop),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .head       (fifo_head),
        .drop_count (drop_count)
    );

    sd_syn_table #(
        .N  (NUM_NEURONS),
        .AW (ADDR_W),
        .WW (WEIGHT_W)
    ) i_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .nrn_we      (nrn_we),
        .nrn_addr    (nrn_addr),
        .nrn_local   (nrn_local),
        .syn_we      (syn_we),
        .syn_pre     (syn_pre),
        .syn_post    (syn_post),
        .syn_plastic (syn_plastic),
        .syn_weight  (syn_weight),
        .syn_excit   (syn_excit),
        .wb_en       (wb_en),
        .wb_pre      (wb_pre),
        .wb_post     (wb_post),
        .wb_weight   (wb_weight),
        .rd_pre      (rd_pre),
        .rd_post     (rd_post),
        .rd_plastic  (rd_plastic),
        .rd_weight   (rd_weight),
        .rd_excit    (rd_excit),
        .rd_local    (rd_local)
    );

    sd_walker #(
        .N  (NUM_NEURONS),
        .AW (ADDR_W),
        .WW (WEIGHT_W)
    ) i_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .fifo_pop   (fifo_pop),
        .rd_pre     (rd_pre),
        .rd_post    (rd_post),
        .rd_plastic (rd_plastic),
        .rd_weight  (rd_weight),
        .rd_excit   (rd_excit),
        .rd_local   (rd_local),
        .wb_en      (wb_en),
        .wb_pre     (wb_pre),
        .wb_post    (wb_post),
        .wb_weight  (wb_weight),
        .eng_valid  (eng_valid),
        .eng_pre    (eng_pre),
        .eng_post   (eng_post),
        .eng_weight (eng_weight),
        .eng_excit  (eng_excit),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .bus_valid  (bus_valid),
        .bus_ready  (bus_ready),
        .bus_src    (bus_src),
        .bus_dst    (bus_dst),
        .dlv_valid  (dlv_valid),
        .dlv_target (dlv_target),
        .dlv_weight (dlv_weight),
        .dlv_excit  (dlv_excit)
    );

    // R9: nothing is requested while reset is held
    p_quiet_in_reset_r9: assert property (@(posedge clk)
        !rst_n |-> !(bus_valid || eng_valid || dlv_valid));

endmodule

// File: tb/test_synapse_dispatch.sv
`timescale 1ns/1ps
module test_synapse_dispatch;
    localparam int NN    = 8;
    localparam int DEP   = 16;
    localparam int WW    = 8;
    localparam int DW    = 4;
    localparam int AW    = 3;
    localparam int CELLS = NN * NN;
    localparam int LAST_CYCLE = 2700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          spike_valid = 0;
    logic [AW-1:0] spike_addr = 0;
    logic          nrn_we = 0, nrn_local = 0;
    logic [AW-1:0] nrn_addr = 0;
    logic          syn_we = 0, syn_plastic = 0, syn_excit = 0;
    logic [AW-1:0] syn_pre = 0, syn_post = 0;
    logic [WW-1:0] syn_weight = 0;
    logic          eng_done = 0;
    logic [WW-1:0] eng_result = 0;
    logic          bus_ready = 0;

    logic          fifo_full, eng_valid, eng_excit, bus_valid, dlv_valid, dlv_excit;
    logic [DW-1:0] drop_count;
    logic [AW-1:0] eng_pre, eng_post, bus_src, bus_dst, dlv_target;
    logic [WW-1:0] eng_weight, dlv_weight;

    synapse_dispatch #(
        .NUM_NEURONS (NN),
        .FIFO_DEPTH  (DEP),
        .WEIGHT_W    (WW),
        .DROP_W      (DW)
    ) i_synapse_dispatch (
        .clk(clk), .rst_n(rst_n),
        .spike_valid(spike_valid), .spike_addr(spike_addr),
        .fifo_full(fifo_full), .drop_count(drop_count),
        .nrn_we(nrn_we), .nrn_addr(nrn_addr), .nrn_local(nrn_local),
        .syn_we(syn_we), .syn_pre(syn_pre), .syn_post(syn_post),
        .syn_plastic(syn_plastic), .syn_weight(syn_weight), .syn_excit(syn_excit),
        .eng_valid(eng_valid), .eng_pre(eng_pre), .eng_post(eng_post),
        .eng_weight(eng_weight), .eng_excit(eng_excit),
        .eng_done(eng_done), .eng_result(eng_result),
        .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_src(bus_src), .bus_dst(bus_dst),
        .dlv_valid(dlv_valid), .dlv_target(dlv_target),
        .dlv_weight(dlv_weight), .dlv_excit(dlv_excit)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int m_st = 0, m_snd = 0, m_tgt = 0, m_drops = 0;
    int fq[$];
    bit m_pl[CELLS];
    bit m_ex[CELLS];
    int m_w[CELLS];
    bit m_loc[NN];

    int n_fwd = 0, n_eng = 0, n_static = 0;
    bit seen_full = 0;
    bit [31:0] lfsr = 32'h1234_5678;
    int eng_wait = -1;

    function automatic bit [31:0] rnd();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_exists(input int c);
        return m_pl[c] || (m_w[c] != 0);
    endfunction

    task automatic model_reset();
        m_st = 0; m_snd = 0; m_tgt = 0; m_drops = 0;
        fq.delete();
        for (int i = 0; i < CELLS; i++) begin
            m_pl[i] = 0; m_ex[i] = 0; m_w[i] = 0;
        end
        for (int i = 0; i < NN; i++) m_loc[i] = 0;
    endtask

    task automatic model_step();
        int c, nst, nsnd, ntgt;
        bit wb, pop, adv;
        if (!rst_n) begin
            model_reset();
            return;
        end
        c = m_snd * NN + m_tgt;
        nst = m_st; nsnd = m_snd; ntgt = m_tgt;
        wb = 0; pop = 0; adv = 0;
        case (m_st)
            0: if (fq.size() > 0) begin pop = 1; nsnd = fq[0]; ntgt = 0; nst = 1; end
            1: begin
                if (!m_exists(c)) adv = 1;
                else if (!m_loc[m_tgt]) nst = 2;
                else if (m_pl[c]) nst = 3;
                else adv = 1;
            end
            2: if (bus_ready) adv = 1;
            3: if (eng_done) begin wb = 1; nst = 4; end
            default: adv = 1;
        endcase
        if (adv) begin
            if (m_tgt == NN - 1) nst = 0;
            else begin ntgt = m_tgt + 1; nst = 1; end
        end
        if (spike_valid) begin
            if (fq.size() == DEP) begin
                if (m_drops < (1 << DW) - 1) m_drops++;
            end else fq.push_back(int'(spike_addr));
        end
        if (pop) void'(fq.pop_front());
        if (nrn_we) m_loc[nrn_addr] = nrn_local;
        if (syn_we) begin
            m_pl[syn_pre * NN + syn_post] = syn_plastic;
            m_ex[syn_pre * NN + syn_post] = syn_excit;
            m_w[syn_pre * NN + syn_post]  = int'(syn_weight);
        end
        if (wb) m_w[c] = int'(eng_result);
        m_st = nst; m_snd = nsnd; m_tgt = ntgt;
    endtask

    task automatic compare_all();
        int c;
        bit e_dlv;
        c = m_snd * NN + m_tgt;
        chk(fifo_full == (fq.size() == DEP), "R2 fifo_full", fifo_full, fq.size() == DEP);
        chk(int'(drop_count) == m_drops, "R2 drop_count", drop_count, m_drops);
        chk(bus_valid == (m_st == 2), "R4 bus_valid", bus_valid, m_st == 2);
        if (bus_valid && m_st == 2) begin
            chk(int'(bus_src) == m_snd, "R1 bus_src", bus_src, m_snd);
            chk(int'(bus_dst) == m_tgt, "R3 bus_dst", bus_dst, m_tgt);
        end
        chk(eng_valid == (m_st == 3), "R5 eng_valid", eng_valid, m_st == 3);
        if (eng_valid && m_st == 3) begin
            chk(int'(eng_pre) == m_snd, "R1 eng_pre", eng_pre, m_snd);
            chk(int'(eng_post) == m_tgt, "R3 eng_post", eng_post, m_tgt);
            chk(int'(eng_weight) == m_w[c], "R8 eng_weight", eng_weight, m_w[c]);
            chk(eng_excit == m_ex[c], "R5 eng_excit", eng_excit, m_ex[c]);
        end
        e_dlv = (m_st == 4) || (m_st == 1 && m_exists(c) && m_loc[m_tgt] && !m_pl[c]);
        if (m_st == 4) begin
            chk(dlv_valid == e_dlv, "R6 dlv_valid", dlv_valid, e_dlv);
        end else begin
            chk(dlv_valid == e_dlv, "R7 dlv_valid", dlv_valid, e_dlv);
        end
        if (dlv_valid && e_dlv) begin
            chk(int'(dlv_target) == m_tgt, "R3 dlv_target", dlv_target, m_tgt);
            if (m_st == 4)
                chk(int'(dlv_weight) == m_w[c], "R6 dlv_weight", dlv_weight, m_w[c]);
            else
                chk(int'(dlv_weight) == m_w[c], "R7 dlv_weight", dlv_weight, m_w[c]);
            chk(dlv_excit == m_ex[c], "R7 dlv_excit", dlv_excit, m_ex[c]);
            if (m_st == 1) n_static++;
        end
        if (bus_valid && bus_ready) n_fwd++;
        if (fifo_full) seen_full = 1;
    endtask

    task automatic drive(input int k);
        bit [31:0] r;
        int p;
        r = rnd();
        spike_valid = 0; nrn_we = 0; syn_we = 0;
        rst_n = (k >= 4);
        p = k - 4;
        if (p >= 0 && p < NN) begin
            nrn_we = 1; nrn_addr = AW'(p); nrn_local = !(p == 5 || p == 6);
        end else if (p >= NN && p < NN + CELLS) begin
            int c, ty;
            c = p - NN;
            ty = ((c / NN) * 3 + (c % NN)) % 5;
            syn_we = 1; syn_pre = AW'(c / NN); syn_post = AW'(c % NN);
            case (ty)
                0: begin syn_plastic = 0; syn_weight = 0; syn_excit = 1; end
                1: begin syn_plastic = 1; syn_weight = WW'(100 + c % NN); syn_excit = 1; end
                2: begin syn_plastic = 1; syn_weight = 50; syn_excit = 0; end
                3: begin syn_plastic = 0; syn_weight = WW'(30 + c / NN); syn_excit = 1; end
                default: begin syn_plastic = 1; syn_weight = 0; syn_excit = 0; end
            endcase
        end else if (p >= NN + CELLS && p < 1500) begin
            spike_valid = (r[4:0] < 6);
            spike_addr  = r[10:8];
            if (r[20:16] == 0) begin
                syn_we = 1; syn_pre = r[23:21]; syn_post = r[26:24];
                syn_plastic = r[27]; syn_excit = r[28]; syn_weight = {r[31:29], r[12:11], 3'b0};
            end
            if (r[15:11] == 5'd3) begin
                nrn_we = 1; nrn_addr = r[30:28]; nrn_local = r[7];
            end
        end else if (p >= 1500 && p < 1560) begin
            spike_valid = 1; spike_addr = r[10:8];
        end
        bus_ready = r[13];
        eng_result = r[31:24];
        eng_done = 0;
        if (eng_valid) begin
            if (eng_wait < 0) eng_wait = int'(r[2:1]);
            if (eng_wait == 0) begin eng_done = 1; eng_wait = -1; n_eng++; end
            else eng_wait--;
        end
    endtask

    initial begin
        model_reset();
        for (int k = 0; k < LAST_CYCLE; k++) begin
            @(negedge clk);
            if (k == 2) begin
                chk(fifo_full == 0, "R9 full after reset", fifo_full, 0);
                chk(drop_count == 0, "R9 drops after reset", drop_count, 0);
                chk(!(bus_valid || eng_valid || dlv_valid), "R9 valids after reset",
                    bus_valid + eng_valid + dlv_valid, 0);
            end
            if (k >= 2) compare_all();
            drive(k);
            @(posedge clk);
            model_step();
        end
        @(negedge clk);
        chk(int'(drop_count) == (1 << DW) - 1, "R2 drop count saturates", drop_count, (1 << DW) - 1);
        chk(seen_full, "R2 queue reached full", seen_full, 1);
        chk(!(bus_valid || eng_valid || dlv_valid) && !fifo_full, "R1 walks drained",
            bus_valid + eng_valid + dlv_valid, 0);
        chk(n_fwd > 0, "R4 remote forwards seen", n_fwd, 1);
        chk(n_eng > 0, "R5 engine completions seen", n_eng, 1);
        chk(n_static > 0, "R7 static deliveries seen", n_static, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule